// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block protects a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable field with a single even-parity line. When the local agent owns the address/data lines, it produces the parity bit and its output enable. Both are registered, so they appear one clock after the lines they cover. The parity bit is the XOR of the 36 covered lines, which makes the number of ones across all 37 bits even.

When the agent watches the bus, it computes the same parity over the observed lines and holds it for one clock. It then compares that value with the parity line, which arrives one clock after the phase it covers. A comparison counts only if the earlier clock was an address phase or a completed transfer, meaning initiator ready and target ready were both high. A mismatch in an address phase, or in a data phase of a broadcast special cycle, pulls the system-error output low. A mismatch in an ordinary data phase pulls the data-parity-error output low. Errors are only reported. Nothing is retried or corrected.

Top module: `bpar_top`

## Requirements
- R1: `par_o` equals the XOR of the 32 driven address/data bits and the 4 driven command bits, so those 36 bits together with `par_o` hold an even number of ones.
- R2: `par_o` covers the drive values sampled at the previous rising edge, so parity lags its data by exactly one clock.
- R3: `par_oe_o` is `ad_oe_i` delayed by one clock. It rises one clock after the agent starts driving and stays high for one clock after `ad_oe_i` falls.
- R4: If parity is wrong for a clock with `addr_phase_i` high, `serr_n_o` goes low for one clock, two clocks after that address phase.
- R5: If parity is wrong for a completed data phase with `special_i` high, `serr_n_o` goes low two clocks later and `perr_n_o` stays high.
- R6: If parity is wrong for a completed ordinary data phase (`irdy_i` and `trdy_i` both high, `addr_phase_i` and `special_i` low), `perr_n_o` goes low for one clock, two clocks after the phase. Back-to-back bad phases give back-to-back low clocks.
- R7: A parity mismatch for a clock that was neither an address phase nor a completed transfer has no effect on either error output.
- R8: Correct parity never drives either error output low.
- R9: Synchronous reset sets `par_o` and `par_oe_o` to 0 and both error outputs to 1, and it drops any error still pending from the clock before.
- R10: An error output holds no state: after a reported error, clean phases leave both outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ad_oe_i | input | 1 | Local agent drives the address/data lines this clock |
| ad_drv_i | input | 32 | Address/data value the agent drives |
| cbe_drv_i | input | 4 | Command/byte-enable value the agent drives |
| ad_bus_i | input | 32 | Address/data value observed on the bus |
| cbe_bus_i | input | 4 | Command/byte-enable value observed on the bus |
| par_bus_i | input | 1 | Parity line observed on the bus |
| addr_phase_i | input | 1 | This clock is an address phase |
| special_i | input | 1 | This clock belongs to a broadcast special cycle |
| irdy_i | input | 1 | Initiator ready (active high) |
| trdy_i | input | 1 | Target ready (active high) |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for the parity line |
| perr_n_o | output | 1 | Data parity error, active low |
| serr_n_o | output | 1 | System error, active low |

## Verification
The bench targets the one-clock skew between a phase and its parity line. A checker that compared parity against the current bus lines would flag clean traffic and miss corrupted phases. The stimulus includes a stall, where only one side is ready, carrying a bad parity bit. A checker that ignored the ready qualification would report a false data error there. Special-cycle data phases and address phases must raise the system error and not the data error, so swapped routing shows up at once. The bench also sends two bad data phases back to back, an enable that falls right after a driven phase, and a reset asserted while an error is pending. These catch sticky error flags, an enable that drops too early, and a reset that fails to clear the pipeline.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

  // Qualifiers captured with a phase and used one clock later,
  // when its parity line arrives.
  typedef struct packed {
    logic addr;   // address phase
    logic spec;   // broadcast special cycle
    logic xfer;   // both ready signals high
  } phase_t;

endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic [DW-1:0] ad,
  input  logic [CW-1:0] cbe,
  output logic          par
);
  localparam int TW = DW + CW;

  logic [TW-1:0] vec;
  assign vec = {ad, cbe};
  assign par = ^vec;
endmodule

// File: rtl/bpar_gen.sv
module bpar_gen #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          oe,
  input  logic [DW-1:0] ad,
  input  logic [CW-1:0] cbe,
  output logic          par,
  output logic          par_oe
);
  logic par_w;

  bpar_tree #(.DW(DW), .CW(CW)) u_tree (
    .ad  (ad),
    .cbe (cbe),
    .par (par_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      par    <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par    <= par_w;
      par_oe <= oe;
    end
  end
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
  import bpar_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ad,
  input  logic [CW-1:0] cbe,
  input  logic          par_in,
  input  phase_t        ph,
  output logic          perr_n,
  output logic          serr_n
);
  logic   par_w;
  logic   calc_q;
  phase_t ph_q;
  logic   mis;
  logic   data_err;
  logic   sys_err;

  bpar_tree #(.DW(DW), .CW(CW)) u_tree (
    .ad  (ad),
    .cbe (cbe),
    .par (par_w)
  );

  always_comb begin
    mis      = calc_q ^ par_in;
    sys_err  = mis & (ph_q.addr | (ph_q.spec & ph_q.xfer));
    data_err = mis & ph_q.xfer & ~ph_q.addr & ~ph_q.spec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      calc_q <= 1'b0;
      ph_q   <= '0;
      perr_n <= 1'b1;
      serr_n <= 1'b1;
    end else begin
      calc_q <= par_w;
      ph_q   <= ph;
      perr_n <= ~data_err;
      serr_n <= ~sys_err;
    end
  end
endmodule

// File: rtl/bpar_top.sv
module bpar_top
  import bpar_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ad_oe_i,
  input  logic [DW-1:0] ad_drv_i,
  input  logic [CW-1:0] cbe_drv_i,
  input  logic [DW-1:0] ad_bus_i,
  input  logic [CW-1:0] cbe_bus_i,
  input  logic          par_bus_i,
  input  logic          addr_phase_i,
  input  logic          special_i,
  input  logic          irdy_i,
  input  logic          trdy_i,
  output logic          par_o,
  output logic          par_oe_o,
  output logic          perr_n_o,
  output logic          serr_n_o
);
  phase_t ph;

  always_comb begin
    ph.addr = addr_phase_i;
    ph.spec = special_i;
    ph.xfer = irdy_i & trdy_i;
  end

  bpar_gen #(.DW(DW), .CW(CW)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .oe     (ad_oe_i),
    .ad     (ad_drv_i),
    .cbe    (cbe_drv_i),
    .par    (par_o),
    .par_oe (par_oe_o)
  );

  bpar_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ad     (ad_bus_i),
    .cbe    (cbe_bus_i),
    .par_in (par_bus_i),
    .ph     (ph),
    .perr_n (perr_n_o),
    .serr_n (serr_n_o)
  );
endmodule

// File: rtl/bpar_sva.sv
module bpar_sva #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ad_oe_i,
  input logic [DW-1:0] ad_drv_i,
  input logic [CW-1:0] cbe_drv_i,
  input logic [DW-1:0] ad_bus_i,
  input logic [CW-1:0] cbe_bus_i,
  input logic          par_bus_i,
  input logic          addr_phase_i,
  input logic          special_i,
  input logic          irdy_i,
  input logic          trdy_i,
  input logic          par_o,
  input logic          par_oe_o,
  input logic          perr_n_o,
  input logic          serr_n_o
);
  // Clocks since reset, saturating at 3; guards every $past.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 3)  age <= age + 2'd1;
  end

  AST_PAR_EVEN_LAG: assert property (@(posedge clk) disable iff (rst)
    (age >= 1) |-> (par_o == ^{$past(ad_drv_i), $past(cbe_drv_i)}));  // R2

  AST_OE_TRAIL: assert property (@(posedge clk) disable iff (rst)
    (age >= 1) |-> (par_oe_o == $past(ad_oe_i)));  // R3

  AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (age >= 2 && !serr_n_o) |->
      ($past(addr_phase_i, 2) || $past(special_i, 2)));  // R4

  AST_PERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (age >= 2 && !perr_n_o) |->
      ($past(irdy_i && trdy_i, 2) && !$past(addr_phase_i, 2)
       && !$past(special_i, 2)));  // R6

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!perr_n_o && !serr_n_o));  // R5

  AST_GOOD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (age >= 1 && par_bus_i == ^{$past(ad_bus_i), $past(cbe_bus_i)})
      |=> (perr_n_o && serr_n_o));  // R8
endmodule

bind bpar_top bpar_sva #(.DW(DW), .CW(CW)) u_sva (.*);

// File: tb/tb_bpar_top.sv
module tb_bpar_top;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          ad_oe_i;
  logic [DW-1:0] ad_drv_i;
  logic [CW-1:0] cbe_drv_i;
  logic [DW-1:0] ad_bus_i;
  logic [CW-1:0] cbe_bus_i;
  logic          par_bus_i;
  logic          addr_phase_i;
  logic          special_i;
  logic          irdy_i;
  logic          trdy_i;
  logic          par_o;
  logic          par_oe_o;
  logic          perr_n_o;
  logic          serr_n_o;

  always #5 clk = ~clk;

  bpar_top #(.DW(DW), .CW(CW)) dut (.*);

  typedef struct packed {
    logic          oe;
    logic [DW-1:0] dad;
    logic [CW-1:0] dcbe;
    logic [DW-1:0] bad_;
    logic [CW-1:0] bcbe;
    logic          adr;
    logic          spc;
    logic          ir;
    logic          tr;
    logic          bad;   // parity line corrupted for this phase
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_0001, 4'h0, 32'h0000_0001, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 32'h0000_0000, 4'h0, 32'h1234_5678, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0000_0000, 4'h0, 32'hA5A5_0F0F, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b0, 32'h0000_0000, 4'h0, 32'h8000_0000, 4'h1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b0, 32'h0000_0000, 4'h0, 32'h0F0F_0F0F, 4'h8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{1'b0, 32'h0000_0000, 4'h0, 32'h7777_0001, 4'h2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 32'hDEAD_BEEF, 4'hA, 32'hDEAD_BEEF, 4'hA, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 32'h0000_0000, 4'h0, 32'h0000_00FF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 32'h0000_0000, 4'h0, 32'h0102_0304, 4'h5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b0, 32'h0000_0000, 4'h0, 32'hCAFE_0000, 4'h9, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 32'h8000_0001, 4'h7, 32'h8000_0001, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 32'h0000_0000, 4'h0, 32'h0000_0000, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  int   n_chk  = 0;
  int   n_fail = 0;
  logic done   = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic pbus);
    ad_oe_i      = v.oe;
    ad_drv_i     = v.dad;
    cbe_drv_i    = v.dcbe;
    ad_bus_i     = v.bad_;
    cbe_bus_i    = v.bcbe;
    addr_phase_i = v.adr;
    special_i    = v.spc;
    irdy_i       = v.ir;
    trdy_i       = v.tr;
    par_bus_i    = pbus;
  endtask

  function automatic logic line_par(input vec_t v);
    return (^{v.bad_, v.bcbe}) ^ v.bad;
  endfunction

  function automatic logic exp_perr_n(input vec_t p);
    return !(p.bad && p.ir && p.tr && !p.adr && !p.spc);
  endfunction

  function automatic logic exp_serr_n(input vec_t p);
    return !(p.bad && (p.adr || (p.spc && p.ir && p.tr)));
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    vec_t idle;
    vec_t prev;
    idle = '0;
    rst  = 1'b1;
    apply(idle, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9 par_o reset",    {31'd0, par_o},    32'd0);
    check("R9 par_oe reset",   {31'd0, par_oe_o}, 32'd0);
    check("R9 perr_n reset",   {31'd0, perr_n_o}, 32'd1);
    check("R9 serr_n reset",   {31'd0, serr_n_o}, 32'd1);
    rst = 1'b0;

    prev = idle;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i], line_par(prev));
      @(posedge clk);
      @(negedge clk);
      // R1 R2: parity of the drive sampled at this edge
      check($sformatf("R1 R2 par_o vec%0d", i), {31'd0, par_o}, {31'd0, ^{VEC[i].dad, VEC[i].dcbe}});
      // R3: enable trails drive enable by one clock
      check($sformatf("R3 par_oe vec%0d", i), {31'd0, par_oe_o}, {31'd0, VEC[i].oe});
      // R4 R5 R6 R7 R8 R10: errors for the phase before
      if (i > 0) begin
        check($sformatf("R6 R7 R8 R10 perr_n phase%0d", i-1), {31'd0, perr_n_o}, {31'd0, exp_perr_n(prev)});
        check($sformatf("R4 R5 R8 R10 serr_n phase%0d", i-1), {31'd0, serr_n_o}, {31'd0, exp_serr_n(prev)});
      end
      prev = VEC[i];
    end

    // R9: reset while a data error is pending
    apply(VEC[3], line_par(prev));
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    apply(idle, line_par(VEC[3]));
    @(posedge clk);
    @(negedge clk);
    check("R9 pending perr dropped", {31'd0, perr_n_o}, 32'd1);
    check("R9 par_oe cleared",       {31'd0, par_oe_o}, 32'd0);
    rst = 1'b0;
    apply(idle, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R9 perr_n after reset", {31'd0, perr_n_o}, 32'd1);
    check("R9 serr_n after reset", {31'd0, serr_n_o}, 32'd1);

    done = 1'b1;
    finish_run();
  end
endmodule